// File: doc/BRIEF.md
# Programmable Propagate/Kill Ripple ALU

This block is a purely combinational arithmetic and logic unit built from a row of identical bit cells. No opcode is decoded inside it. Instead, three 4-bit truth-table words, shared by every cell, define what the block computes.

In each cell, one word turns the two operand bits into a propagate term and a second word turns them into a kill term. A fixed carry rule combines these terms with the incoming carry to produce the carry for the next cell up. The third word turns the propagate term and the incoming carry into the result bit.

Suitable word settings give addition, the bitwise logic operations and pass-through. The surrounding datapath supplies the operands, the carry-in and the three words, and takes back the result and the final carry.

Top module: `pk_ripple_alu`

## Requirements
- R1: Every lookup returns one bit of its 4-bit word, chosen by two select bits (first, second): 00 picks bit 0, 01 picks bit 1, 10 picks bit 2 and 11 picks bit 3.
- R2: In cell i, the propagate term is `p_word` looked up with selects (opa[i], opb[i]).
- R3: In cell i, the kill term is `k_word` looked up with the same selects (opa[i], opb[i]). The carry leaving the cell is (p AND carry entering) OR (NOT p AND NOT k).
- R4: Result bit i is `r_word` looked up with selects (p, carry entering cell i).
- R5: `carry_i` enters cell 0. The carry leaving cell i enters cell i+1. The carry leaving the top cell drives `carry_o`.
- R6: With p_word=4'b0110, k_word=4'b0001 and r_word=4'b0110, {carry_o, result_o} equals opa+opb+carry_i.
- R7: With p_word=4'b1000 and r_word=4'b1100, result_o equals opa AND opb for any k_word and carry_i.
- R8: With r_word=4'b1100, p_word=4'b0110 gives opa XOR opb, and p_word=4'b1100 gives opa, regardless of carry.
- R9: Chain corner cases hold. With p_word=4'b1111, carry_o equals carry_i. With p_word=4'b0000 and k_word=4'b1111, carry_o is 0. With p_word=4'b0000 and k_word=4'b0000, carry_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (8) | First operand |
| opb | input | WIDTH (8) | Second operand |
| carry_i | input | 1 | Carry into the lowest cell |
| p_word | input | 4 | Truth table for the propagate term |
| k_word | input | 4 | Truth table for the kill term |
| r_word | input | 4 | Truth table for the result bit |
| result_o | output | WIDTH (8) | Result |
| carry_o | output | 1 | Carry out of the highest cell |

## Verification
The checker tests the named settings on every evaluation, for any operands and carry. These are the add sum, the AND, XOR and pass-a results, and the three carry-chain corner cases. The behaviour under arbitrary control words can only be shown by the bench's scenarios, which compare against a behavioural model. These scenarios include the select order of each lookup and the position at which a carry stops partway up the chain.

// File: rtl/pk_alu_pkg.sv
package pk_alu_pkg;
   localparam int SEL_W = 2;
   localparam int CTL_W = 1 << SEL_W;
   typedef logic [CTL_W-1:0] ctl_word_t;
   localparam int LUT_MUX = 0;
   localparam int LUT_SOP = 1;
endpackage

// File: rtl/pk_lut4.sv
module pk_lut4
   import pk_alu_pkg::*;
#(
   parameter int IMPL = LUT_MUX
) (
   input  logic      sel_x,
   input  logic      sel_y,
   input  ctl_word_t table_i,
   output logic      bit_o
);
   generate
      if (IMPL == LUT_MUX) begin : g_mux
         always_comb bit_o = table_i[{sel_x, sel_y}];
      end else if (IMPL == LUT_SOP) begin : g_sop
         always_comb
            bit_o = (~sel_x & ~sel_y & table_i[0]) |
                    (~sel_x &  sel_y & table_i[1]) |
                    ( sel_x & ~sel_y & table_i[2]) |
                    ( sel_x &  sel_y & table_i[3]);
      end else begin : g_bad
         $error("pk_lut4: IMPL must be LUT_MUX or LUT_SOP");
         assign bit_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pk_bit_slice.sv
module pk_bit_slice
   import pk_alu_pkg::*;
#(
   parameter int IMPL = LUT_MUX
) (
   input  logic      a_bit,
   input  logic      b_bit,
   input  logic      c_in,
   input  ctl_word_t p_tab,
   input  ctl_word_t k_tab,
   input  ctl_word_t r_tab,
   output logic      r_bit,
   output logic      c_out
);
   logic prop, kill;

   pk_lut4 #(.IMPL(IMPL)) u_prop (
      .sel_x(a_bit), .sel_y(b_bit), .table_i(p_tab), .bit_o(prop));
   pk_lut4 #(.IMPL(IMPL)) u_kill (
      .sel_x(a_bit), .sel_y(b_bit), .table_i(k_tab), .bit_o(kill));

   always_comb c_out = (prop & c_in) | (~prop & ~kill);

   pk_lut4 #(.IMPL(IMPL)) u_res (
      .sel_x(prop), .sel_y(c_in), .table_i(r_tab), .bit_o(r_bit));
endmodule

// File: rtl/pk_ripple_alu.sv
module pk_ripple_alu
   import pk_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int IMPL  = LUT_MUX
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             carry_i,
   input  logic [CTL_W-1:0] p_word,
   input  logic [CTL_W-1:0] k_word,
   input  logic [CTL_W-1:0] r_word,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o
);
   localparam int CHAIN_N = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_chk_w
         $error("pk_ripple_alu: WIDTH must be at least 1");
      end
      if (IMPL != LUT_MUX && IMPL != LUT_SOP) begin : g_chk_i
         $error("pk_ripple_alu: unknown IMPL");
      end
   endgenerate

   logic [CHAIN_N-1:0] chain;

   assign chain[0] = carry_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      pk_bit_slice #(.IMPL(IMPL)) u_cell (
         .a_bit (opa[i]),
         .b_bit (opb[i]),
         .c_in  (chain[i]),
         .p_tab (p_word),
         .k_tab (k_word),
         .r_tab (r_word),
         .r_bit (result_o[i]),
         .c_out (chain[i+1])
      );
   end

   assign carry_o = chain[CHAIN_N-1];
endmodule

// File: rtl/pk_ripple_alu_chk.sv
module pk_ripple_alu_chk
   import pk_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             carry_i,
   input logic [CTL_W-1:0] p_word,
   input logic [CTL_W-1:0] k_word,
   input logic [CTL_W-1:0] r_word,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_o
);
   logic [WIDTH:0] sum_ref;
   always_comb sum_ref = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_i};

   always_comb begin
      if (p_word == 4'b0110 && k_word == 4'b0001 && r_word == 4'b0110)
         assert_add_sum_R6: assert ({carry_o, result_o} == sum_ref)
            else $error("add setting mismatch");
      if (p_word == 4'b1000 && r_word == 4'b1100)
         assert_and_R7: assert (result_o == (opa & opb))
            else $error("and setting mismatch");
      if (p_word == 4'b0110 && r_word == 4'b1100)
         assert_xor_R8: assert (result_o == (opa ^ opb))
            else $error("xor setting mismatch");
      if (p_word == 4'b1100 && r_word == 4'b1100)
         assert_pass_a_R8: assert (result_o == opa)
            else $error("pass-a setting mismatch");
      if (p_word == 4'b1111)
         assert_prop_all_R9: assert (carry_o == carry_i)
            else $error("full propagate mismatch");
      if (p_word == 4'b0000 && k_word == 4'b1111)
         assert_kill_all_R9: assert (carry_o == 1'b0)
            else $error("full kill mismatch");
      if (p_word == 4'b0000 && k_word == 4'b0000)
         assert_gen_all_R9: assert (carry_o == 1'b1)
            else $error("full generate mismatch");
   end
endmodule

bind pk_ripple_alu pk_ripple_alu_chk #(.WIDTH(WIDTH)) chk_i (
   .opa(opa), .opb(opb), .carry_i(carry_i),
   .p_word(p_word), .k_word(k_word), .r_word(r_word),
   .result_o(result_o), .carry_o(carry_o));

// File: tb/pk_ripple_alu_tb_top.sv
module pk_ripple_alu_tb_top;
   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] opa, opb, result_o;
   logic         carry_i, carry_o;
   logic [3:0]   p_word, k_word, r_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   pk_ripple_alu #(.WIDTH(W)) dut_i (
      .opa(opa), .opb(opb), .carry_i(carry_i),
      .p_word(p_word), .k_word(k_word), .r_word(r_word),
      .result_o(result_o), .carry_o(carry_o));

   // behavioural model straight from R1..R5
   function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic ci, input logic [3:0] pw,
                                        input logic [3:0] kw, input logic [3:0] rw);
      logic [W-1:0] r;
      logic c, p, k;
      int idx;
      c = ci;
      for (int i = 0; i < W; i++) begin
         idx = 2 * int'(a[i]) + int'(b[i]);
         p = pw[idx];
         k = kw[idx];
         r[i] = rw[2 * int'(p) + int'(c)];
         c = p ? c : ~k;
      end
      return {c, r};
   endfunction

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                        input logic [3:0] pw, input logic [3:0] kw, input logic [3:0] rw);
      @(posedge clk);
      opa = a; opb = b; carry_i = ci; p_word = pw; k_word = kw; r_word = rw;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [W:0] exp);
      checks++;
      if ({carry_o, result_o} !== exp) begin
         errors++;
         $display("FAIL %s p=%b k=%b r=%b a=%h b=%h ci=%b actual=%h expected=%h",
                  req, p_word, k_word, r_word, opa, opb, carry_i,
                  {carry_o, result_o}, exp);
      end
   endtask

   initial begin
      opa = '0; opb = '0; carry_i = 1'b0; p_word = '0; k_word = '0; r_word = '0;
      // idle state: all-zero words give carry generate everywhere, result zero (R5, R9)
      @(negedge clk);
      check("R5 idle", {1'b1, {W{1'b0}}});

      // R1: result table alone, p forced to 1 and 0 by p_word
      drive(8'h00, 8'h00, 1'b0, 4'b1111, 4'b0000, 4'b0100); // p=1,c=0 -> bit2
      check("R1 sel10", {1'b0, 8'hFF});
      drive(8'h00, 8'h00, 1'b1, 4'b1111, 4'b0000, 4'b1000); // p=1,c=1 -> bit3
      check("R1 sel11", {1'b1, 8'hFF});
      drive(8'h00, 8'h00, 1'b1, 4'b0000, 4'b1111, 4'b0010); // bit0 p=0,c=1 -> bit1; rest c=0
      check("R1 sel01", {1'b0, 8'h01});

      // R2: propagate table select order via pass of one operand position
      drive(8'hA5, 8'h3C, 1'b0, 4'b0010, 4'b1111, 4'b1100); // p = ~a & b
      check("R2 order", model(8'hA5, 8'h3C, 1'b0, 4'b0010, 4'b1111, 4'b1100));
      // R3: kill stops carry partway up the chain
      drive(8'h0F, 8'h00, 1'b1, 4'b1100, 4'b1111, 4'b1000);
      check("R3 kill stop", {1'b0, 8'h0F});
      drive(8'h0F, 8'h00, 1'b1, 4'b1100, 4'b0000, 4'b1000);
      check("R3 generate", {1'b1, 8'h0F});
      // R4: result depends on carry entering each cell
      drive(8'h00, 8'h00, 1'b1, 4'b1111, 4'b0000, 4'b1000);
      check("R4 carry ripple", {1'b1, 8'hFF});
      // R5: carry_i reaches carry_o through full propagate
      drive(8'h5A, 8'hC3, 1'b0, 4'b1111, 4'b0101, 4'b0000);
      check("R5 cin0", {1'b0, 8'h00});
      // R9 corners
      drive(8'hFF, 8'h00, 1'b1, 4'b1111, 4'b0000, 4'b0000);
      check("R9 prop", {1'b1, 8'h00});
      drive(8'hFF, 8'hFF, 1'b1, 4'b0000, 4'b1111, 4'b0000);
      check("R9 kill", {1'b0, 8'h00});
      drive(8'h12, 8'h34, 1'b0, 4'b0000, 4'b0000, 4'b0000);
      check("R9 gen", {1'b1, 8'h00});
      // R6 edges
      drive(8'hFF, 8'h00, 1'b1, 4'b0110, 4'b0001, 4'b0110);
      check("R6 wrap", {1'b1, 8'h00});
      drive(8'hFF, 8'hFF, 1'b1, 4'b0110, 4'b0001, 4'b0110);
      check("R6 max", 9'h1FF);

      // named settings with random operands, both carries
      for (int n = 0; n < 400; n++) begin
         logic [W-1:0] a, b;
         logic ci;
         logic [3:0] kw;
         a = W'($urandom); b = W'($urandom); ci = n[0]; kw = 4'($urandom);
         drive(a, b, ci, 4'b0110, 4'b0001, 4'b0110);
         check("R6 add", {1'b0, a} + {1'b0, b} + {8'h00, ci});
         drive(a, b, ci, 4'b1000, kw, 4'b1100);
         checks++;
         if (result_o !== (a & b)) begin
            errors++;
            $display("FAIL R7 and actual=%h expected=%h", result_o, a & b);
         end
         drive(a, b, ci, 4'b0110, kw, 4'b1100);
         checks++;
         if (result_o !== (a ^ b)) begin
            errors++;
            $display("FAIL R8 xor actual=%h expected=%h", result_o, a ^ b);
         end
         drive(a, b, ci, 4'b1100, kw, 4'b1100);
         checks++;
         if (result_o !== a) begin
            errors++;
            $display("FAIL R8 pass-a actual=%h expected=%h", result_o, a);
         end
      end

      // arbitrary control words against the model (R1..R5)
      for (int n = 0; n < 1000; n++) begin
         logic [W-1:0] a, b;
         logic ci;
         logic [3:0] pw, kw, rw;
         a = W'($urandom); b = W'($urandom); ci = 1'($urandom);
         pw = 4'($urandom); kw = 4'($urandom); rw = 4'($urandom);
         drive(a, b, ci, pw, kw, rw);
         check("R2 R3 R4 random", model(a, b, ci, pw, kw, rw));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule